// File: doc/BRIEF.md
# Streaming 3x3 Sobel Edge Filter

The block turns a raster-ordered stream of 8-bit luma samples into a stream of 8-bit edge strengths. It accepts one sample per clock under a valid/ready handshake and takes each sample exactly once. Two row memories keep the two rows above the current one, and a 3x3 register window slides one column for every sample taken. Each window is weighted by two run-time coefficient sets, one for the horizontal gradient and one for the vertical gradient. The output is |Gx|+|Gy|, clipped to 255.

Output samples follow input order and are centred on the window, so the output lags the input by one row plus one sample. When the last sample of a frame has been taken, the block stops accepting input and flushes the outstanding outputs. Samples on the outer ring of the frame come out as zero. A downstream back-pressure stall freezes the whole pipeline. Frame width and height are parameters. The coefficients are loaded through a small write port while the stream is idle.

Top module: `sobel_stream`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: With in_valid and out_ready held high, a whole frame of COLS*ROWS input samples is accepted on consecutive clocks, one per cycle.
- R3: Every frame yields exactly COLS*ROWS outputs in raster order. Output k (raster index) is presented only after input sample k+COLS+1 of the frame has been accepted, or, for the last COLS+1 outputs, after all inputs have been accepted. Once the last input of a frame has been taken, in_ready stays low until the flush has produced those outputs.
- R4: An output whose position is in the first or last row, or in the first or last column, is 0.
- R5: Any other output at (r,c) equals min(255, |Gx|+|Gy|). Here Gx is the sum of kx[3i+j]*p(r-1+i, c-1+j) over i,j in 0..2, and Gy is the same sum taken with ky. i counts rows downward and j counts columns rightward.
- R6: A write with coef_we=1 stores coef_wdata, a 16-bit two's-complement value, into tap coef_idx (index 3i+j as in R5) of the X set when coef_sel=0, or of the Y set when coef_sel=1. Reset loads X = {-1,0,1,-2,0,2,-1,0,1} and Y = {-1,-2,-1,0,0,0,1,2,1}.
- R7: out_sof is 1 exactly on output (0,0) of a frame, and out_eol is 1 exactly on outputs in column COLS-1.
- R8: While out_valid=1 and out_ready=0, out_data, out_sof and out_eol hold their values, out_valid stays 1 and in_ready is 0. No sample is lost or duplicated.
- R9: A sample taken with in_sof=1 is placed at (0,0) of a new frame. Samples from an interrupted earlier frame never reach an interior output of the new frame.
- R10: If |Gx|+|Gy| exceeds 255, the output is 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block takes the sample this cycle |
| in_data | input | PIX_W | Input luma sample |
| in_sof | input | 1 | Sample is the first of a frame |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output |
| out_data | output | PIX_W | Edge strength |
| out_sof | output | 1 | Output is the first of a frame |
| out_eol | output | 1 | Output is the last of a row |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 1 | 0 selects the X set, 1 the Y set |
| coef_idx | input | 4 | Tap index 3i+j |
| coef_wdata | input | 16 | Signed coefficient value |

## Verification
The in-line assertions check the per-cycle rules on every cycle. A stalled output must hold its data and markers. Input must close right after the last sample of a frame. Any output flagged as a row end or frame start must carry zero. Row-memory addresses and output coordinates must stay in range. Coefficient writes must target a real tap. Only the bench scenarios can show that the values are right: interior gradients under the reset kernels, under a loaded centre-only kernel and under saturating weights. The same holds for raster order and per-frame output counts, the one-sample-per-clock rate, and the recovery from a frame cut short by a new start-of-frame.

// File: rtl/sobel_pkg.sv
// Shared definitions for the Sobel stream filter.
// Holds the coefficient type, the tap count and the reset kernel values.
package sobel_pkg;
    parameter int KW   = 16;
    parameter int TAPS = 9;

    typedef logic signed [KW-1:0] coef_t;
    typedef enum logic {KSET_X = 1'b0, KSET_Y = 1'b1} kset_e;

    // Reset value of tap idx (3*row + col) for the chosen gradient set.
    function automatic coef_t default_tap(input kset_e set, input int idx);
        int r;
        int c;
        int w;
        r = idx / 3;
        c = idx % 3;
        if (set == KSET_X) begin
            w = (r == 1) ? 2 : 1;
            return coef_t'((c - 1) * w);
        end
        w = (c == 1) ? 2 : 1;
        return coef_t'((r - 1) * w);
    endfunction
endpackage

// File: rtl/sobel_linebuf.sv
// One row of sample storage, addressed by column.
// Reads are asynchronous, so a read and a write to the same column in one
// cycle return the old content. The memory has no reset; its users must
// never depend on contents that were not written in the current frame.
module sobel_linebuf #(
    parameter  int DEPTH = 1920,
    parameter  int W     = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store one sample per accepted input at its column.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    // R3: each write lands inside the row.
    assert_lb_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(addr) < DEPTH));
endmodule

// File: rtl/sobel_coef_regs.sv
// Programmable X and Y gradient coefficient sets, nine signed taps each.
// A write may land at any time; the user keeps writes to stream idle time.
module sobel_coef_regs
    import sobel_pkg::*;
#(
    localparam int IW = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  kset_e         set,
    input  logic [IW-1:0] idx,
    input  coef_t         wdata,
    output coef_t         kx [TAPS],
    output coef_t         ky [TAPS]
);
    // Load reset kernels, then accept single-tap writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < TAPS; t++) begin
                kx[t] <= default_tap(KSET_X, t);
                ky[t] <= default_tap(KSET_Y, t);
            end
        end else if (we && (int'(idx) < TAPS)) begin
            if (set == KSET_X) kx[idx] <= wdata;
            else               ky[idx] <= wdata;
        end
    end

    // R6: writes address an existing tap.
    assert_coef_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(idx) < TAPS));
endmodule

// File: rtl/sobel_gradient.sv
// Combinational 3x3 weighting and magnitude.
// Forms both gradient sums, adds the absolute values and clips the result
// to the largest sample value. Accumulators are sized so they cannot overflow.
module sobel_gradient
    import sobel_pkg::*;
#(
    parameter  int PIX_W = 8,
    localparam int ACC_W = PIX_W + KW + 5
) (
    input  logic [PIX_W-1:0] win [TAPS],
    input  coef_t            kx  [TAPS],
    input  coef_t            ky  [TAPS],
    output logic [PIX_W-1:0] mag
);
    localparam logic [ACC_W:0] MAXV = (ACC_W+1)'((1 << PIX_W) - 1);

    logic signed [ACC_W-1:0] gx;
    logic signed [ACC_W-1:0] gy;
    logic        [ACC_W-1:0] ax;
    logic        [ACC_W-1:0] ay;
    logic        [ACC_W:0]   sum;

    // Multiply-accumulate over the nine taps for both sets.
    always_comb begin
        logic signed [ACC_W-1:0] pe;
        gx = '0;
        gy = '0;
        for (int t = 0; t < TAPS; t++) begin
            pe = ACC_W'($signed({1'b0, win[t]}));
            gx = gx + pe * ACC_W'(kx[t]);
            gy = gy + pe * ACC_W'(ky[t]);
        end
    end

    // Absolute values, sum and clip.
    always_comb begin
        ax  = gx[ACC_W-1] ? ACC_W'(-gx) : ACC_W'(gx);
        ay  = gy[ACC_W-1] ? ACC_W'(-gy) : ACC_W'(gy);
        sum = {1'b0, ax} + {1'b0, ay};
        mag = (sum > MAXV) ? '1 : sum[PIX_W-1:0];
    end
endmodule

// File: rtl/sobel_stream.sv
// Streaming 3x3 Sobel edge filter, top level.
// Takes raster samples under valid/ready. Two row memories and a 3x3 window
// supply the neighbourhood. Output k appears after input k+COLS+1; a flush
// of COLS+1 steps follows the last input of each frame. A low out_ready
// freezes every stage. Assumes coefficients change only while idle.
module sobel_stream
    import sobel_pkg::*;
#(
    parameter  int COLS   = 1920,
    parameter  int ROWS   = 1080,
    parameter  int PIX_W  = 8,
    localparam int CW     = $clog2(COLS),
    localparam int RW     = $clog2(ROWS),
    localparam int FW     = $clog2(COLS + 2),
    localparam int IW     = $clog2(TAPS),
    localparam int LB_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_data,
    input  logic             in_sof,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_data,
    output logic             out_sof,
    output logic             out_eol,
    input  logic             coef_we,
    input  logic             coef_sel,
    input  logic [IW-1:0]    coef_idx,
    input  logic [KW-1:0]    coef_wdata
);
    localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
    localparam logic [FW-1:0] LEAD     = FW'(COLS + 1);

    // Control state
    logic [RW-1:0] in_row_q, row_eff, oc_row;
    logic [CW-1:0] in_col_q, col_eff, oc_col;
    logic [FW-1:0] fill_q, fill_idx, flush_cnt;
    logic          flush_q;
    logic          adv, in_hs, tick, sof_hit, last_in, emit;

    // Datapath state
    logic [PIX_W-1:0] win [3][3];
    logic [PIX_W-1:0] win_flat [TAPS];
    logic [PIX_W-1:0] newcol [3];
    logic [PIX_W-1:0] lb_wd [LB_N];
    logic [PIX_W-1:0] lb_rd [LB_N];
    logic [PIX_W-1:0] mag;
    coef_t            kx [TAPS];
    coef_t            ky [TAPS];

    logic             a_valid, a_border, a_sof, a_eol;
    logic             ov_q, osof_q, oeol_q;
    logic [PIX_W-1:0] od_q;

    // Step conditions: advance, accept, tick and output emission.
    always_comb begin
        adv      = !ov_q || out_ready;
        in_ready = adv && !flush_q;
        in_hs    = in_valid && in_ready;
        tick     = in_hs || (flush_q && adv);
        sof_hit  = in_hs && in_sof;
        col_eff  = sof_hit ? '0 : in_col_q;
        row_eff  = sof_hit ? '0 : in_row_q;
        last_in  = in_hs && (row_eff == ROW_LAST) && (col_eff == COL_LAST);
        fill_idx = sof_hit ? '0 : fill_q;
        emit     = tick && (fill_idx >= LEAD);
    end

    // Row memories: the first stores the input, the next stores the row above.
    for (genvar k = 0; k < LB_N; k++) begin : g_lb
        if (k == 0) begin : g_first
            assign lb_wd[k] = in_data;
        end else begin : g_chain
            assign lb_wd[k] = lb_rd[k-1];
        end
        sobel_linebuf #(.DEPTH(COLS), .W(PIX_W)) i_lb (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (in_hs),
            .addr  (col_eff),
            .wdata (lb_wd[k]),
            .rdata (lb_rd[k])
        );
    end

    // Column entering the window: oldest row on top, zeros while flushing.
    always_comb begin
        newcol[0] = flush_q ? '0 : lb_rd[1];
        newcol[1] = flush_q ? '0 : lb_rd[0];
        newcol[2] = flush_q ? '0 : in_data;
    end

    // Slide the window by one column per tick; a frame start clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                win[i][0] <= '0;
                win[i][1] <= '0;
                win[i][2] <= '0;
            end
        end else if (tick) begin
            for (int i = 0; i < 3; i++) begin
                win[i][0] <= sof_hit ? '0 : win[i][1];
                win[i][1] <= sof_hit ? '0 : win[i][2];
                win[i][2] <= newcol[i];
            end
        end
    end

    // Present the window as nine taps in 3*row+col order.
    always_comb begin
        for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 3; j++) begin
                win_flat[3*i + j] = win[i][j];
            end
        end
    end

    // Track input position, fill depth, flush and output position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_row_q  <= '0;
            in_col_q  <= '0;
            flush_q   <= 1'b0;
            flush_cnt <= '0;
            fill_q    <= '0;
            oc_row    <= '0;
            oc_col    <= '0;
        end else begin
            if (in_hs) begin
                if (col_eff == COL_LAST) begin
                    in_col_q <= '0;
                    in_row_q <= (row_eff == ROW_LAST) ? '0 : row_eff + 1'b1;
                end else begin
                    in_col_q <= col_eff + 1'b1;
                    in_row_q <= row_eff;
                end
            end
            if (last_in) begin
                flush_q   <= 1'b1;
                flush_cnt <= LEAD;
            end
            if (tick) begin
                fill_q <= (fill_idx >= LEAD) ? fill_idx : fill_idx + 1'b1;
            end
            if (sof_hit) begin
                oc_row <= '0;
                oc_col <= '0;
            end else if (emit) begin
                if (oc_col == COL_LAST) begin
                    oc_col <= '0;
                    oc_row <= oc_row + 1'b1;
                end else begin
                    oc_col <= oc_col + 1'b1;
                end
            end
            if (flush_q && adv) begin
                flush_cnt <= flush_cnt - 1'b1;
                if (flush_cnt == FW'(1)) begin
                    flush_q <= 1'b0;
                    fill_q  <= '0;
                    oc_row  <= '0;
                    oc_col  <= '0;
                end
            end
        end
    end

    sobel_coef_regs i_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .set   (kset_e'(coef_sel)),
        .idx   (coef_idx),
        .wdata (coef_t'(coef_wdata)),
        .kx    (kx),
        .ky    (ky)
    );

    sobel_gradient #(.PIX_W(PIX_W)) i_grad (
        .win (win_flat),
        .kx  (kx),
        .ky  (ky),
        .mag (mag)
    );

    // Two pipeline stages: position tags, then the registered result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_valid  <= 1'b0;
            a_border <= 1'b0;
            a_sof    <= 1'b0;
            a_eol    <= 1'b0;
            ov_q     <= 1'b0;
            od_q     <= '0;
            osof_q   <= 1'b0;
            oeol_q   <= 1'b0;
        end else if (adv) begin
            a_valid  <= emit;
            a_border <= (oc_row == '0) || (oc_row == ROW_LAST) ||
                        (oc_col == '0) || (oc_col == COL_LAST);
            a_sof    <= (oc_row == '0) && (oc_col == '0);
            a_eol    <= (oc_col == COL_LAST);
            ov_q     <= a_valid;
            od_q     <= a_border ? '0 : mag;
            osof_q   <= a_valid && a_sof;
            oeol_q   <= a_valid && a_eol;
        end
    end

    assign out_valid = ov_q;
    assign out_data  = od_q;
    assign out_sof   = osof_q;
    assign out_eol   = oeol_q;

    // R8: a stalled output keeps its contents.
    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                       $stable(out_sof) && $stable(out_eol)));

    // R3: input closes right after the final sample of a frame.
    assert_close_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_sof && (in_row_q == ROW_LAST) &&
         (in_col_q == COL_LAST)) |=> !in_ready);

    // R4: frame-start and row-end outputs sit on the border.
    assert_border_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_sof || out_eol)) |-> (out_data == '0));

    // R7: output coordinates stay inside the frame.
    assert_pos_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(oc_col) < COLS) && (int'(oc_row) < ROWS));
endmodule

// File: tb/test_sobel_stream.sv
// Bench: behavioural reference with queues, compared on every clock.
module test_sobel_stream;
    localparam int C = 6;
    localparam int R = 5;
    localparam int N = C * R;
    localparam int LIMIT = 100000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_ready, in_sof;
    logic [7:0] in_data;
    logic       out_valid, out_ready, out_sof, out_eol;
    logic [7:0] out_data;
    logic       coef_we, coef_sel;
    logic [3:0] coef_idx;
    logic [15:0] coef_wdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int img [R][C];
    int kxm [9];
    int kym [9];
    int q_d [$];
    int q_k [$];
    bit q_s [$];
    bit q_e [$];
    bit q_b [$];
    int acc_cnt = 0;
    int first_acc = 0;
    int last_acc = 0;
    string tag = "R5";
    int rdy_mode = 0;
    bit prev_stall = 1'b0;
    int prev_data = 0;
    bit mon_on = 1'b0;

    always #5 clk = ~clk;

    sobel_stream #(.COLS(C), .ROWS(R), .PIX_W(8)) i_sobel_stream (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sof(in_sof), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
        .out_eol(out_eol), .coef_we(coef_we), .coef_sel(coef_sel),
        .coef_idx(coef_idx), .coef_wdata(coef_wdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_px(input int r, input int c);
        int gx;
        int gy;
        int m;
        if (r == 0 || r == R-1 || c == 0 || c == C-1) return 0;
        gx = 0;
        gy = 0;
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++) begin
                gx += kxm[3*i+j] * img[r-1+i][c-1+j];
                gy += kym[3*i+j] * img[r-1+i][c-1+j];
            end
        m = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
        return (m > 255) ? 255 : m;
    endfunction

    task automatic build_exp();
        q_d.delete(); q_k.delete(); q_s.delete(); q_e.delete(); q_b.delete();
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) begin
                q_d.push_back(ref_px(r, c));
                q_k.push_back(r*C + c);
                q_s.push_back(r == 0 && c == 0);
                q_e.push_back(c == C-1);
                q_b.push_back(r == 0 || r == R-1 || c == 0 || c == C-1);
            end
    endtask

    always @(posedge clk) cyc++;

    // Drive downstream ready away from the edge.
    always @(posedge clk) begin
        #2;
        out_ready = (rdy_mode == 0) ? 1'b1 : ($urandom % 3 != 0);
    end

    // Per-cycle comparison against the reference queues.
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (prev_stall) begin
                chk(out_valid && (int'(out_data) == prev_data), "R8", int'(out_data), prev_data);
            end
            if (out_valid && !out_ready) begin
                chk(!in_ready, "R8", int'(in_ready), 0);
            end
            if (out_valid && out_ready) begin
                if (q_d.size() == 0) begin
                    chk(1'b0, "R3", 1, 0);
                end else begin
                    int ed, ek, need;
                    bit es, ee, eb;
                    ed = q_d.pop_front(); ek = q_k.pop_front();
                    es = q_s.pop_front(); ee = q_e.pop_front(); eb = q_b.pop_front();
                    chk(int'(out_data) == ed, eb ? "R4" : tag, int'(out_data), ed);
                    chk(out_sof == es, "R7", int'(out_sof), int'(es));
                    chk(out_eol == ee, "R7", int'(out_eol), int'(ee));
                    need = (ek + C + 2 < N) ? ek + C + 2 : N;
                    chk(acc_cnt >= need, "R3", acc_cnt, need);
                end
            end
            if (in_valid && in_ready) begin
                acc_cnt++;
                if (acc_cnt == 1) first_acc = cyc;
                last_acc = cyc;
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = int'(out_data);
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic send(input int px, input bit sof);
        in_data = px[7:0]; in_sof = sof; in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready || cyc > LIMIT) break;
        end
        step();
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic wr_coef(input bit sel, input int idx, input int val);
        coef_we = 1'b1; coef_sel = sel; coef_idx = idx[3:0]; coef_wdata = val[15:0];
        step();
        coef_we = 1'b0;
        if (sel) kym[idx] = val; else kxm[idx] = val;
    endtask

    task automatic load_defaults();
        int dx [9] = '{-1, 0, 1, -2, 0, 2, -1, 0, 1};
        int dy [9] = '{-1, -2, -1, 0, 0, 0, 1, 2, 1};
        for (int t = 0; t < 9; t++) begin
            wr_coef(1'b0, t, dx[t]);
            wr_coef(1'b1, t, dy[t]);
        end
    endtask

    task automatic drain(input string t);
        while (q_d.size() > 0 && cyc < LIMIT) @(posedge clk);
        repeat (4) step();
        chk(q_d.size() == 0, t, q_d.size(), 0);
    endtask

    task automatic run_frame(input string t, input bit gaps, input bit sof);
        tag = t;
        acc_cnt = 0;
        build_exp();
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) begin
                send(img[r][c], sof && r == 0 && c == 0);
                if (gaps && ($urandom % 2 == 1)) step();
            end
        drain(t);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_data = '0;
        out_ready = 1'b1; coef_we = 1'b0; coef_sel = 1'b0; coef_idx = '0; coef_wdata = '0;
        kxm = '{-1, 0, 1, -2, 0, 2, -1, 0, 1};
        kym = '{-1, -2, -1, 0, 0, 0, 1, 2, 1};
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
        mon_on = 1'b1;
        step();

        // R5 and R2: reset kernels, ramp image, no back-pressure.
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) img[r][c] = (r*40 + c*23 + (r*c*7)) % 256;
        run_frame("R5", 1'b0, 1'b1);
        chk(last_acc - first_acc == N-1, "R2", last_acc - first_acc, N-1);

        // R8: random pixels, random input gaps and downstream stalls.
        rdy_mode = 1;
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) img[r][c] = $urandom % 256;
        run_frame("R8", 1'b1, 1'b1);
        rdy_mode = 0;

        // R6: centre-only X kernel, zero Y kernel; no start marker given.
        for (int t = 0; t < 9; t++) begin
            wr_coef(1'b0, t, (t == 4) ? 1 : 0);
            wr_coef(1'b1, t, 0);
        end
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) img[r][c] = $urandom % 256;
        run_frame("R6", 1'b0, 1'b0);

        // R10: large positive X weights force clipping.
        for (int t = 0; t < 9; t++) wr_coef(1'b0, t, 100);
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) img[r][c] = 50 + ($urandom % 200);
        run_frame("R10", 1'b0, 1'b1);

        // R9: a cut-short frame of bright samples, then a fresh start.
        load_defaults();
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) img[r][c] = (c == 2) ? 200 : 10 + r;
        tag = "R9";
        build_exp();
        for (int k = 0; k < 4; k++) send(255, k == 0);
        step();
        acc_cnt = 0;
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) send(img[r][c], r == 0 && c == 0);
        drain("R9");

        if (cyc >= LIMIT) chk(1'b0, "R3 watchdog", cyc, LIMIT);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #(LIMIT * 10 + 5000);
        chk(1'b0, "R3 watchdog", cyc, LIMIT);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule